// File: doc/BRIEF.md
# Segmented Address Generation Unit

This block forms the memory address for a load or store in a segmented 32-bit machine. Each request carries a base register, an index with a 2-bit scale, a signed displacement, the segment base and the segment limit, an access size and a tag. A single four-operand adder produces the linear address. That address leaves the block one cycle after the request is accepted, and it goes to the access path whatever the limit check finds.

A second adder runs alongside the first. It sums only the three effective-address operands, so the segment base is not part of it. A separate pipeline stage then checks the last byte of the access against the segment limit. That verdict comes out one cycle after the linear address and carries the same tag. Downstream logic uses it to keep a violating access from committing. The check never stalls the input and never removes an address that has already been issued.

Top module: `seg_agu`

## Requirements
- R1: One cycle after a request is accepted (`valid_i && ready_o` at a rising edge), `lin_valid_o` is high and `lin_addr_o` holds base + scaled index + displacement + segment base, modulo 2^32. `lin_tag_o` holds the request tag.
- R2: `scale_i` multiplies the index: code 0 by 1, code 1 by 2, code 2 by 4, code 3 by 8.
- R3: Exactly one cycle after each `lin_valid_o` pulse, `flt_valid_o` is high and `flt_tag_o` equals the tag on that linear address.
- R4: The effective address (EA) is base + scaled index + displacement modulo 2^32, without the segment base. `flt_o` is high when EA + bytes − 1 is greater than `seg_limit_i` (unsigned) and low when it is equal or below.
- R5: `flt_o` is high when EA + bytes − 1 carries past 2^32 − 1, whatever the limit.
- R6: `size_i` selects the access width: code 0 is 1 byte, code 1 is 2 bytes, code 2 is 4 bytes, and code 3 is also treated as 4 bytes.
- R7: The linear address is issued for every accepted request, faulting or not. A wrap of the linear sum past 2^32 raises no fault by itself.
- R8: `ready_o` is high from the first rising edge after reset release, so requests on consecutive cycles are all accepted.
- R9: While `rst_ni` is low, `ready_o`, `lin_valid_o` and `flt_valid_o` are low, and requests in flight are dropped.
- R10: With no request accepted, neither output valid is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request valid |
| ready_o | output | 1 | Request accepted when high |
| base_i | input | 32 | Base register operand |
| index_i | input | 32 | Index register operand |
| scale_i | input | 2 | Index scale code |
| disp_i | input | 32 | Sign-extended displacement |
| seg_base_i | input | 32 | Segment base |
| seg_limit_i | input | 32 | Segment limit (expand-up) |
| size_i | input | 2 | Access size code |
| tag_i | input | 4 | Request tag |
| lin_valid_o | output | 1 | Linear address valid |
| lin_addr_o | output | 32 | Linear address |
| lin_tag_o | output | 4 | Tag of the linear address |
| flt_valid_o | output | 1 | Limit verdict valid |
| flt_o | output | 1 | Limit violation |
| flt_tag_o | output | 4 | Tag of the verdict |

## Verification
Corrupted operands in the first stage show up on `lin_addr_o` on the next cycle. A wrong effective address, size or limit carried into the check stage shows as a wrong `flt_o` one cycle later. A tag or valid bit that slips between the two paths shows at once as a verdict whose tag does not match, or as a verdict with no address in the cycle before it. Boundary cases are where off-by-one and carry mistakes show: last byte equal to the limit, one past it, and carries out of the top bit on either adder.

// File: rtl/seg_agu_pkg.sv
package seg_agu_pkg;
  typedef enum logic [1:0] {
    SZ_B1  = 2'd0,
    SZ_B2  = 2'd1,
    SZ_B4  = 2'd2,
    SZ_B4X = 2'd3
  } acc_size_e;

  // bytes - 1 for the access width
  function automatic logic [1:0] size_span(input logic [1:0] code);
    case (acc_size_e'(code))
      SZ_B1:   size_span = 2'd0;
      SZ_B2:   size_span = 2'd1;
      default: size_span = 2'd3;
    endcase
  endfunction
endpackage

// File: rtl/seg_agu_lin.sv
module seg_agu_lin #(
  parameter int AW = 32,
  parameter int TW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fire_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] sidx_i,
  input  logic [AW-1:0] disp_i,
  input  logic [AW-1:0] seg_base_i,
  input  logic [TW-1:0] tag_i,
  output logic          valid_o,
  output logic [AW-1:0] addr_o,
  output logic [TW-1:0] tag_o
);
  logic [AW-1:0] sum4;

  // unified four-operand adder, modulo 2^AW
  assign sum4 = base_i + sidx_i + disp_i + seg_base_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
      tag_o   <= '0;
    end else begin
      valid_o <= fire_i;
      if (fire_i) begin
        addr_o <= sum4;
        tag_o  <= tag_i;
      end
    end
  end
endmodule

// File: rtl/seg_agu_lim.sv
module seg_agu_lim #(
  parameter int AW = 32,
  parameter int TW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fire_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] sidx_i,
  input  logic [AW-1:0] disp_i,
  input  logic [AW-1:0] limit_i,
  input  logic [1:0]    size_i,
  input  logic [TW-1:0] tag_i,
  output logic          valid_o,
  output logic          flt_o,
  output logic [TW-1:0] tag_o
);
  import seg_agu_pkg::*;

  logic [AW-1:0] ea_d;
  logic          s1_v;
  logic [AW-1:0] s1_ea, s1_lim;
  logic [1:0]    s1_span;
  logic [TW-1:0] s1_tag;
  logic [AW:0]   last_b;
  logic          viol;

  // separate three-operand adder, no segment base
  assign ea_d = base_i + sidx_i + disp_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_v    <= 1'b0;
      s1_ea   <= '0;
      s1_lim  <= '0;
      s1_span <= '0;
      s1_tag  <= '0;
    end else begin
      s1_v <= fire_i;
      if (fire_i) begin
        s1_ea   <= ea_d;
        s1_lim  <= limit_i;
        s1_span <= size_span(size_i);
        s1_tag  <= tag_i;
      end
    end
  end

  // carry-out of the last-byte sum is itself a violation
  assign last_b = {1'b0, s1_ea} + {{(AW-1){1'b0}}, s1_span};
  assign viol   = last_b[AW] | (last_b[AW-1:0] > s1_lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      flt_o   <= 1'b0;
      tag_o   <= '0;
    end else begin
      valid_o <= s1_v;
      if (s1_v) begin
        flt_o <= viol;
        tag_o <= s1_tag;
      end
    end
  end
endmodule

// File: rtl/seg_agu.sv
module seg_agu #(
  parameter int AW = 32,
  parameter int TW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  output logic          ready_o,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] index_i,
  input  logic [1:0]    scale_i,
  input  logic [AW-1:0] disp_i,
  input  logic [AW-1:0] seg_base_i,
  input  logic [AW-1:0] seg_limit_i,
  input  logic [1:0]    size_i,
  input  logic [TW-1:0] tag_i,
  output logic          lin_valid_o,
  output logic [AW-1:0] lin_addr_o,
  output logic [TW-1:0] lin_tag_o,
  output logic          flt_valid_o,
  output logic          flt_o,
  output logic [TW-1:0] flt_tag_o
);
  logic          rdy_q;
  logic          fire;
  logic [AW-1:0] sidx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdy_q <= 1'b0;
    else         rdy_q <= 1'b1;
  end

  assign ready_o = rdy_q;
  assign fire    = valid_i & rdy_q;
  assign sidx    = index_i << scale_i;

  seg_agu_lin #(.AW(AW), .TW(TW)) u_lin (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fire_i     (fire),
    .base_i     (base_i),
    .sidx_i     (sidx),
    .disp_i     (disp_i),
    .seg_base_i (seg_base_i),
    .tag_i      (tag_i),
    .valid_o    (lin_valid_o),
    .addr_o     (lin_addr_o),
    .tag_o      (lin_tag_o)
  );

  seg_agu_lim #(.AW(AW), .TW(TW)) u_lim (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fire_i  (fire),
    .base_i  (base_i),
    .sidx_i  (sidx),
    .disp_i  (disp_i),
    .limit_i (seg_limit_i),
    .size_i  (size_i),
    .tag_i   (tag_i),
    .valid_o (flt_valid_o),
    .flt_o   (flt_o),
    .tag_o   (flt_tag_o)
  );
endmodule

// File: rtl/seg_agu_chk.sv
module seg_agu_chk #(
  parameter int AW = 32,
  parameter int TW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic          ready_o,
  input logic [AW-1:0] base_i,
  input logic [AW-1:0] index_i,
  input logic [1:0]    scale_i,
  input logic [AW-1:0] disp_i,
  input logic [AW-1:0] seg_base_i,
  input logic [TW-1:0] tag_i,
  input logic          lin_valid_o,
  input logic [AW-1:0] lin_addr_o,
  input logic [TW-1:0] lin_tag_o,
  input logic          flt_valid_o,
  input logic [TW-1:0] flt_tag_o
);
  AST_READY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o); // R8

  AST_LIN_ISSUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o) |=> (lin_valid_o && lin_tag_o == $past(tag_i))); // R1

  AST_LIN_SUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o) |=> lin_addr_o == $past(base_i + (index_i << scale_i)
                                                  + disp_i + seg_base_i)); // R7

  AST_FLT_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lin_valid_o |=> (flt_valid_o && flt_tag_o == $past(lin_tag_o))); // R3

  AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && ready_o) |=> !lin_valid_o); // R10

  AST_FLT_ORPHAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lin_valid_o |=> !flt_valid_o); // R10
endmodule

bind seg_agu seg_agu_chk #(.AW(AW), .TW(TW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .ready_o     (ready_o),
  .base_i      (base_i),
  .index_i     (index_i),
  .scale_i     (scale_i),
  .disp_i      (disp_i),
  .seg_base_i  (seg_base_i),
  .tag_i       (tag_i),
  .lin_valid_o (lin_valid_o),
  .lin_addr_o  (lin_addr_o),
  .lin_tag_o   (lin_tag_o),
  .flt_valid_o (flt_valid_o),
  .flt_tag_o   (flt_tag_o)
);

// File: tb/seg_agu_bench.sv
module seg_agu_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic        ready_o;
  logic [31:0] base_i = '0, index_i = '0, disp_i = '0, seg_base_i = '0, seg_limit_i = '0;
  logic [1:0]  scale_i = '0, size_i = '0;
  logic [3:0]  tag_i = '0;
  logic        lin_valid_o, flt_valid_o, flt_o;
  logic [31:0] lin_addr_o;
  logic [3:0]  lin_tag_o, flt_tag_o;

  int n_chk = 0;
  int n_bad = 0;
  string cur_lbl = "R1";

  always #5 clk_i = ~clk_i;

  seg_agu u_seg_agu (
    .clk_i, .rst_ni, .valid_i, .ready_o, .base_i, .index_i, .scale_i, .disp_i,
    .seg_base_i, .seg_limit_i, .size_i, .tag_i, .lin_valid_o, .lin_addr_o,
    .lin_tag_o, .flt_valid_o, .flt_o, .flt_tag_o
  );

  // reference model
  logic        m_up;
  logic        e1_v, e2_v, e1_f, e2_f;
  logic [31:0] e1_a;
  logic [3:0]  e1_t, e2_t;
  string       e1_l, e2_l;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_up <= 1'b0; e1_v <= 1'b0; e2_v <= 1'b0;
      e1_f <= 1'b0; e2_f <= 1'b0; e1_a <= '0; e1_t <= '0; e2_t <= '0;
      e1_l <= ""; e2_l <= "";
    end else begin
      longint ea, la, last, nb;
      m_up <= 1'b1;
      e2_v <= e1_v; e2_f <= e1_f; e2_t <= e1_t; e2_l <= e1_l;
      e1_v <= valid_i && m_up;
      if (valid_i && m_up) begin
        ea = (longint'(base_i) + longint'(index_i) * (longint'(1) << scale_i)
              + longint'(disp_i)) % 64'h1_0000_0000;
        la = (ea + longint'(seg_base_i)) % 64'h1_0000_0000;
        nb = (size_i == 2'd0) ? 1 : (size_i == 2'd1) ? 2 : 4;
        last = ea + nb - 1;
        e1_a <= la[31:0];
        e1_f <= (last > longint'(seg_limit_i));
        e1_t <= tag_i;
        e1_l <= cur_lbl;
      end
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni) begin
      chk("R8", "ready_o", ready_o, m_up);
      chk((e1_v ? "R1" : "R10"), "lin_valid_o", lin_valid_o, e1_v);
      if (e1_v && lin_valid_o) begin
        chk(e1_l, "lin_addr_o", lin_addr_o, e1_a);
        chk("R1", "lin_tag_o", lin_tag_o, e1_t);
      end
      chk("R3", "flt_valid_o", flt_valid_o, e2_v);
      if (e2_v && flt_valid_o) begin
        chk(e2_l, "flt_o", flt_o, e2_f);
        chk("R3", "flt_tag_o", flt_tag_o, e2_t);
      end
    end
  end

  task automatic send(input string lbl, input logic [31:0] b, input logic [31:0] ix,
                      input logic [1:0] sc, input logic [31:0] d, input logic [31:0] sb,
                      input logic [31:0] lim, input logic [1:0] sz, input logic [3:0] t);
    @(negedge clk_i);
    cur_lbl = lbl; valid_i = 1'b1;
    base_i = b; index_i = ix; scale_i = sc; disp_i = d;
    seg_base_i = sb; seg_limit_i = lim; size_i = sz; tag_i = t;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      valid_i = 1'b0;
    end
  endtask

  initial begin
    #2000000;
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R9", "ready_o in reset", ready_o, 0);
    chk("R9", "lin_valid_o in reset", lin_valid_o, 0);
    chk("R9", "flt_valid_o in reset", flt_valid_o, 0);
    rst_ni = 1'b1;
    idle(3);
    // R1 basic
    send("R1", 32'h1000, 32'h10, 2'd0, 32'h4, 32'h2000_0000, 32'hFFFF_FFFF, 2'd2, 4'h1);
    // R2 each scale
    for (int s = 0; s < 4; s++)
      send("R2", 32'h100, 32'h3, 2'(s), 32'h0, 32'h10, 32'hFFFF, 2'd0, 4'(s + 2));
    // R4 boundary: last byte equal to limit, then one past
    send("R4", 32'h0FFD, 32'h0, 2'd0, 32'h0, 32'h0, 32'h1000, 2'd2, 4'h7);
    send("R4", 32'h0FFE, 32'h0, 2'd0, 32'h0, 32'h0, 32'h1000, 2'd2, 4'h8);
    send("R4", 32'h1000, 32'h0, 2'd0, 32'h0, 32'h0, 32'h1000, 2'd0, 4'h9);
    send("R4", 32'h1001, 32'h0, 2'd0, 32'h0, 32'h0, 32'h1000, 2'd0, 4'hA);
    // R4 segment base excluded from check
    send("R4", 32'h10, 32'h0, 2'd0, 32'h0, 32'hF000_0000, 32'h100, 2'd1, 4'hB);
    // R5 last-byte carry past 2^32
    send("R5", 32'hFFFF_FFFE, 32'h0, 2'd0, 32'h0, 32'h0, 32'hFFFF_FFFF, 2'd2, 4'hC);
    send("R5", 32'hFFFF_FFFF, 32'h0, 2'd0, 32'h0, 32'h0, 32'hFFFF_FFFF, 2'd0, 4'hD);
    // R6 size codes at boundary
    send("R6", 32'h0FFF, 32'h0, 2'd0, 32'h0, 32'h0, 32'h1000, 2'd1, 4'hE);
    send("R6", 32'h0FFE, 32'h0, 2'd0, 32'h0, 32'h0, 32'h1000, 2'd3, 4'hF);
    send("R6", 32'h0FFD, 32'h0, 2'd0, 32'h0, 32'h0, 32'h1000, 2'd3, 4'h0);
    // R7 linear wrap, negative displacement, faulting access still issued
    send("R7", 32'h10, 32'h0, 2'd0, 32'hFFFF_FFF0, 32'hFFFF_FF00, 32'hFFFF_FFFF, 2'd0, 4'h3);
    send("R7", 32'h8000_0000, 32'h0, 2'd0, 32'h0, 32'h9000_0000, 32'h10, 2'd2, 4'h4);
    idle(4);
    // R9 reset with requests in flight
    send("R9", 32'h20, 32'h1, 2'd1, 32'h0, 32'h0, 32'hFF, 2'd0, 4'h5);
    send("R9", 32'h20, 32'h1, 2'd1, 32'h0, 32'h0, 32'h1, 2'd0, 4'h6);
    #1 rst_ni = 1'b0;
    #1;
    chk("R9", "lin_valid_o after reset", lin_valid_o, 0);
    chk("R9", "flt_valid_o after reset", flt_valid_o, 0);
    valid_i = 1'b0;
    idle(2);
    rst_ni = 1'b1;
    idle(2);
    // R8 back-to-back random stream
    for (int i = 0; i < 300; i++) begin
      logic [31:0] b;
      b = $urandom;
      send("R8", b, $urandom, 2'($urandom), ((i % 3) == 0) ? 32'hFFFF_FF80 : 32'($urandom % 256),
           $urandom, (i % 2) ? b : $urandom, 2'($urandom), 4'($urandom));
      if ((i % 37) == 36) idle(2);
    end
    idle(5);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule